// File: doc/BRIEF.md
# 802.15.4 Automatic Acknowledgement Responder

This block sits behind an IEEE 802.15.4 receive path. The parser before it presents the fields of a received frame in parallel: frame control, sequence number, destination PAN ID, destination address, MAC command identifier and an FCS-valid flag. A one-cycle strobe marks the moment the last symbol has been received. The block compares the destination addressing fields with its configured PAN ID, short address and 64-bit extended address. It then raises an address-match pulse and an end-of-frame pulse, and decides by itself whether the frame is answered.

When an answer is due, the block counts a configured number of symbol ticks. It then sends a 5-byte acknowledgement MPDU over a valid/ready byte handshake. The ACK carries the received sequence number and a frame-pending bit, which follows the data-request policy. Its two trailing FCS bytes come from an external CRC engine, or are fixed placeholder values when that variant is selected. A busy flag covers the whole span from the frame strobe to the hand-off of the last ACK byte. Frames that arrive while busy are ignored.

Top module: `ack_responder`

## Requirements
- R1: An ACK is considered only when bit 5 of the frame control field is set and the frame type field `frm_fcf[2:0]` is 001 (data) or 011 (MAC command). Any other type, or a cleared bit 5, gets no ACK.
- R2: An ACK is scheduled only when the FCS is valid and both the destination PAN ID and the destination address match. The destination addressing mode is `frm_fcf[11:10]`: 10 is short, using `frm_dst_addr[15:0]`, and 11 is extended, using all 64 bits. Any other mode never matches.
- R3: While `cfg_ack_dis` is high, no ACK is scheduled, whatever the request bit says.
- R4: A destination PAN ID of 0xFFFF matches any configured PAN ID. A short destination of 0xFFFF matches any configured short address. A frame sent to the short broadcast address is never acknowledged.
- R5: `addr_match` pulses for one cycle, in the cycle after an accepted frame strobe, when the PAN ID and destination address match.
- R6: `frame_end` pulses for one cycle, in the cycle after an accepted frame strobe, unless the address match fails and the FCS is invalid. With `cfg_promisc` high it pulses for every accepted frame.
- R7: Let N be TURN_SYMS, or FAST_SYMS when `cfg_fast_ack` is high at the strobe. `ack_valid` first rises at the clock edge that samples the N-th `sym_tick` pulse following the edge that took the strobe.
- R8: The ACK bytes, in send order, are: {3'b000, pending, 1'b0, 3'b010}, 8'h00, the received sequence number, crc[7:0], crc[15:8]. The CRC value is sampled when sending starts.
- R9: The pending bit equals `cfg_pend` only when the frame is a MAC command (type 011) with command identifier 0x04. In every other case it is 0.
- R10: An ACK byte and `ack_valid` stay unchanged until `ack_ready` is high. A byte advances only on a cycle where `ack_valid` and `ack_ready` are both high.
- R11: `busy` is high from the cycle after a strobe that schedules an ACK until the last byte is accepted. A strobe while busy has no effect on any output.
- R12: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick | input | 1 | One-cycle pulse per 16 us symbol period |
| cfg_pan_id | input | 16 | Own PAN ID |
| cfg_short_addr | input | 16 | Own short address |
| cfg_ext_addr | input | 64 | Own extended address |
| cfg_pend | input | 1 | Pending value for data-request ACKs |
| cfg_ack_dis | input | 1 | Suppress all ACKs |
| cfg_promisc | input | 1 | Indicate every frame end |
| cfg_fast_ack | input | 1 | Use the shorter turnaround |
| frm_done | input | 1 | Frame-received strobe, fields valid |
| frm_fcf | input | 16 | Frame control field |
| frm_seq | input | 8 | Sequence number |
| frm_dst_pan | input | 16 | Destination PAN ID |
| frm_dst_addr | input | 64 | Destination address (short in low 16 bits) |
| frm_cmd_id | input | 8 | MAC command identifier |
| frm_fcs_ok | input | 1 | Received FCS valid |
| crc_in | input | 16 | FCS for the ACK from the CRC engine |
| ack_ready | input | 1 | Downstream takes the current byte |
| ack_valid | output | 1 | ACK byte valid |
| ack_data | output | 8 | ACK byte |
| addr_match | output | 1 | Address-match pulse |
| frame_end | output | 1 | End-of-frame pulse |
| busy | output | 1 | Turnaround or ACK send in progress |

## Verification
The bench builds the block with TURN_SYMS=12, FAST_SYMS=3 and FCS_EXT=1. The symbol tick comes every fourth clock, so both turnarounds complete in a few dozen cycles. Together with a stalling ready pattern, this exercises the countdown boundary and held bytes. The external-CRC variant puts a frame-specific value in the last two bytes, so the FCS byte order is observable.

// File: rtl/ack_pkg.sv
package ack_pkg;
  localparam logic [2:0]  FT_DATA      = 3'b001;
  localparam logic [2:0]  FT_CMD       = 3'b011;
  localparam logic [2:0]  FT_ACK       = 3'b010;
  localparam logic [1:0]  AM_SHORT     = 2'b10;
  localparam logic [1:0]  AM_EXT       = 2'b11;
  localparam logic [7:0]  CMD_DATA_REQ = 8'h04;
  localparam logic [15:0] BCAST16      = 16'hFFFF;
  localparam int          ACK_LEN      = 5;

  typedef struct packed {
    logic match;
    logic fend;
    logic go;
    logic pend;
  } filt_res_t;
endpackage

// File: rtl/ack_filter.sv
module ack_filter
  import ack_pkg::*;
(
  input  logic [15:0] fcf,
  input  logic [15:0] dst_pan,
  input  logic [63:0] dst_addr,
  input  logic [7:0]  cmd_id,
  input  logic        fcs_ok,
  input  logic [15:0] cfg_pan_id,
  input  logic [15:0] cfg_short_addr,
  input  logic [63:0] cfg_ext_addr,
  input  logic        cfg_pend,
  input  logic        cfg_ack_dis,
  input  logic        cfg_promisc,
  output filt_res_t   res
);
  logic [2:0] ftype;
  logic [1:0] amode;
  logic       pan_ok;
  logic       addr_ok;
  logic       bcast_dst;
  logic       ack_type;
  logic       unused_fcf;

  assign ftype      = fcf[2:0];
  assign amode      = fcf[11:10];
  assign unused_fcf = ^{fcf[15:12], fcf[9:6], fcf[4:3]};

  always_comb begin
    pan_ok    = (dst_pan == cfg_pan_id) || (dst_pan == BCAST16);
    addr_ok   = 1'b0;
    bcast_dst = 1'b0;
    case (amode)
      AM_SHORT: begin
        bcast_dst = (dst_addr[15:0] == BCAST16);
        addr_ok   = (dst_addr[15:0] == cfg_short_addr) || bcast_dst;
      end
      AM_EXT:   addr_ok = (dst_addr == cfg_ext_addr);
      default:  addr_ok = 1'b0;
    endcase
    ack_type  = (ftype == FT_DATA) || (ftype == FT_CMD);
    res.match = pan_ok && addr_ok;
    res.fend  = res.match || fcs_ok || cfg_promisc;
    res.go    = fcf[5] && ack_type && fcs_ok && res.match && !bcast_dst && !cfg_ack_dis;
    res.pend  = (ftype == FT_CMD) && (cmd_id == CMD_DATA_REQ) && cfg_pend;
  end
endmodule

// File: rtl/ack_timer.sv
module ack_timer #(
  parameter int TURN_SYMS = 12,
  parameter int FAST_SYMS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  input  logic sym_tick,
  output logic waiting,
  output logic expire
);
  localparam int MAX_SYMS = (TURN_SYMS > FAST_SYMS) ? TURN_SYMS : FAST_SYMS;
  localparam int CW       = $clog2(MAX_SYMS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wait_q, wait_d;

  assign waiting = wait_q;
  assign expire  = wait_q && sym_tick && (cnt_q == CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    wait_d = wait_q;
    if (start) begin
      wait_d = 1'b1;
      cnt_d  = fast ? CW'(FAST_SYMS) : CW'(TURN_SYMS);
    end else if (wait_q && sym_tick) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
    end
  end

  // R7: without a tick the countdown neither moves nor ends
  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !sym_tick && !start) |=> (wait_q && $stable(cnt_q)));
  // R7: the wait ends exactly on the expiry pulse
  a_r7_end_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !expire && !start) |=> wait_q);
endmodule

// File: rtl/ack_tx.sv
module ack_tx
  import ack_pkg::*;
#(
  parameter bit         FCS_EXT = 1'b1,
  parameter logic [7:0] PH_LO   = 8'h00,
  parameter logic [7:0] PH_HI   = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  seq,
  input  logic        pend,
  input  logic [15:0] crc,
  input  logic        ready,
  output logic        valid,
  output logic [7:0]  data,
  output logic        sending
);
  localparam int IW = $clog2(ACK_LEN);

  logic [IW-1:0] idx_q, idx_d;
  logic          send_q, send_d;
  logic [7:0]    fcs_lo, fcs_hi;
  logic          last;

  generate
    if (FCS_EXT) begin : g_ext_fcs
      logic [15:0] crc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '0;
        else if (load) crc_q <= crc;
      end
      assign fcs_lo = crc_q[7:0];
      assign fcs_hi = crc_q[15:8];
    end else begin : g_placeholder_fcs
      logic unused_crc;
      assign unused_crc = ^crc;
      assign fcs_lo = PH_LO;
      assign fcs_hi = PH_HI;
    end
  endgenerate

  assign last    = (idx_q == IW'(ACK_LEN - 1));
  assign valid   = send_q;
  assign sending = send_q;

  always_comb begin
    data = 8'h00;
    if (send_q) begin
      case (idx_q)
        IW'(0):  data = {3'b000, pend, 1'b0, FT_ACK};
        IW'(1):  data = 8'h00;
        IW'(2):  data = seq;
        IW'(3):  data = fcs_lo;
        default: data = fcs_hi;
      endcase
    end
  end

  always_comb begin
    idx_d  = idx_q;
    send_d = send_q;
    if (load) begin
      send_d = 1'b1;
      idx_d  = '0;
    end else if (send_q && ready) begin
      if (last) send_d = 1'b0;
      else      idx_d  = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      send_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      send_q <= send_d;
    end
  end

  // R10: a stalled byte stays put
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
  // R8: the first byte always carries the acknowledgement frame type
  a_r8_first_is_ack_type: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_q) |-> (data[2:0] == FT_ACK && data[7:5] == 3'b000));
endmodule

// File: rtl/ack_responder.sv
module ack_responder
  import ack_pkg::*;
#(
  parameter int         TURN_SYMS = 12,
  parameter int         FAST_SYMS = 2,
  parameter bit         FCS_EXT   = 1'b1,
  parameter logic [7:0] PH_LO     = 8'h00,
  parameter logic [7:0] PH_HI     = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sym_tick,
  input  logic [15:0] cfg_pan_id,
  input  logic [15:0] cfg_short_addr,
  input  logic [63:0] cfg_ext_addr,
  input  logic        cfg_pend,
  input  logic        cfg_ack_dis,
  input  logic        cfg_promisc,
  input  logic        cfg_fast_ack,
  input  logic        frm_done,
  input  logic [15:0] frm_fcf,
  input  logic [7:0]  frm_seq,
  input  logic [15:0] frm_dst_pan,
  input  logic [63:0] frm_dst_addr,
  input  logic [7:0]  frm_cmd_id,
  input  logic        frm_fcs_ok,
  input  logic [15:0] crc_in,
  input  logic        ack_ready,
  output logic        ack_valid,
  output logic [7:0]  ack_data,
  output logic        addr_match,
  output logic        frame_end,
  output logic        busy
);
  logic [1:0] rst_sync;
  logic       rst_ni;
  filt_res_t  res;
  logic       accept, start, waiting, expire, sending;
  logic       am_q, fe_q;
  logic [7:0] seq_q;
  logic       pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  ack_filter u_filter (
    .fcf            (frm_fcf),
    .dst_pan        (frm_dst_pan),
    .dst_addr       (frm_dst_addr),
    .cmd_id         (frm_cmd_id),
    .fcs_ok         (frm_fcs_ok),
    .cfg_pan_id     (cfg_pan_id),
    .cfg_short_addr (cfg_short_addr),
    .cfg_ext_addr   (cfg_ext_addr),
    .cfg_pend       (cfg_pend),
    .cfg_ack_dis    (cfg_ack_dis),
    .cfg_promisc    (cfg_promisc),
    .res            (res)
  );

  assign busy   = waiting || sending;
  assign accept = frm_done && !busy;
  assign start  = accept && res.go;

  ack_timer #(.TURN_SYMS(TURN_SYMS), .FAST_SYMS(FAST_SYMS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start    (start),
    .fast     (cfg_fast_ack),
    .sym_tick (sym_tick),
    .waiting  (waiting),
    .expire   (expire)
  );

  ack_tx #(.FCS_EXT(FCS_EXT), .PH_LO(PH_LO), .PH_HI(PH_HI)) u_tx (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (expire),
    .seq     (seq_q),
    .pend    (pend_q),
    .crc     (crc_in),
    .ready   (ack_ready),
    .valid   (ack_valid),
    .data    (ack_data),
    .sending (sending)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      am_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      am_q <= accept && res.match;
      fe_q <= accept && res.fend;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= '0;
      pend_q <= 1'b0;
    end else if (start) begin
      seq_q  <= frm_seq;
      pend_q <= res.pend;
    end
  end

  assign addr_match = am_q;
  assign frame_end  = fe_q;

  // R3: a disabled responder never goes busy on a new frame
  a_r3_disable_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && cfg_ack_dis) |=> !busy);
  // R2: a bad FCS never schedules an answer
  a_r2_bad_fcs_no_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !frm_fcs_ok) |=> !busy);
  // R11: bytes are only offered while busy
  a_r11_valid_within_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_valid |-> busy);
  // R11: a strobe during busy raises no indication
  a_r11_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (frm_done && busy) |=> (!addr_match && !frame_end));
  // R6: a frame whose address is matched always reports its end
  a_r6_match_implies_end: assert property (@(posedge clk) disable iff (!rst_ni)
    addr_match |-> frame_end);
endmodule

// File: tb/ack_responder_test.sv
module ack_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int TURN       = 12;
  localparam int FAST       = 3;

  logic        clk, rst_n, sym_tick;
  logic [15:0] cfg_pan_id, cfg_short_addr;
  logic [63:0] cfg_ext_addr;
  logic        cfg_pend, cfg_ack_dis, cfg_promisc, cfg_fast_ack;
  logic        frm_done;
  logic [15:0] frm_fcf, frm_dst_pan, crc_in;
  logic [7:0]  frm_seq, frm_cmd_id;
  logic [63:0] frm_dst_addr;
  logic        frm_fcs_ok, ack_ready;
  logic        ack_valid, addr_match, frame_end, busy;
  logic [7:0]  ack_data;

  ack_responder #(.TURN_SYMS(TURN), .FAST_SYMS(FAST), .FCS_EXT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick),
    .cfg_pan_id(cfg_pan_id), .cfg_short_addr(cfg_short_addr), .cfg_ext_addr(cfg_ext_addr),
    .cfg_pend(cfg_pend), .cfg_ack_dis(cfg_ack_dis), .cfg_promisc(cfg_promisc),
    .cfg_fast_ack(cfg_fast_ack), .frm_done(frm_done), .frm_fcf(frm_fcf), .frm_seq(frm_seq),
    .frm_dst_pan(frm_dst_pan), .frm_dst_addr(frm_dst_addr), .frm_cmd_id(frm_cmd_id),
    .frm_fcs_ok(frm_fcs_ok), .crc_in(crc_in), .ack_ready(ack_ready),
    .ack_valid(ack_valid), .ack_data(ack_data), .addr_match(addr_match),
    .frame_end(frame_end), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int tick_div = 0;

  // reference model state
  int m_st = 0;   // 0 idle, 1 turnaround, 2 sending
  int m_cnt = 0;
  int m_idx = 0;
  logic [7:0] m_b [5];
  bit m_am = 0, m_fe = 0;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural filter/decision model
  task automatic decide(output bit mt, output bit fe, output bit go, output bit pd);
    bit pan, adr, bc, typ_ok;
    pan = (frm_dst_pan == cfg_pan_id) || (frm_dst_pan == 16'hFFFF);
    bc  = 0;
    adr = 0;
    if (frm_fcf[11:10] == 2'b10) begin
      bc  = (frm_dst_addr[15:0] == 16'hFFFF);
      adr = bc || (frm_dst_addr[15:0] == cfg_short_addr);
    end else if (frm_fcf[11:10] == 2'b11) begin
      adr = (frm_dst_addr == cfg_ext_addr);
    end
    mt = pan && adr;
    fe = cfg_promisc || mt || frm_fcs_ok;
    typ_ok = (frm_fcf[2:0] == 3'd1) || (frm_fcf[2:0] == 3'd3);
    go = frm_fcf[5] && typ_ok && frm_fcs_ok && mt && !bc && !cfg_ack_dis;
    pd = cfg_pend && (frm_fcf[2:0] == 3'd3) && (frm_cmd_id == 8'h04);
  endtask

  always @(posedge clk) begin
    int st0;
    bit mt, fe, go, pd;
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
    if (!rst_n) begin
      m_st = 0; m_am = 0; m_fe = 0; m_idx = 0;
    end else begin
      st0 = m_st;
      m_am = 0;
      m_fe = 0;
      if (m_st == 2) begin
        if (ack_ready) begin
          if (m_idx == 4) m_st = 0;
          else m_idx++;
        end
      end else if (m_st == 1 && sym_tick) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_st = 2;
          m_idx = 0;
          m_b[3] = crc_in[7:0];
          m_b[4] = crc_in[15:8];
        end
      end
      if (frm_done && st0 == 0) begin
        decide(mt, fe, go, pd);
        m_am = mt;
        m_fe = fe;
        if (go) begin
          m_st = 1;
          m_cnt = cfg_fast_ack ? FAST : TURN;
          m_b[0] = 8'h02 | (pd ? 8'h10 : 8'h00);
          m_b[1] = 8'h00;
          m_b[2] = frm_seq;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R12 ack_valid in reset", {15'd0, ack_valid}, 16'd0);
      chk("R12 busy in reset", {15'd0, busy}, 16'd0);
      chk("R12 pulses in reset", {14'd0, addr_match, frame_end}, 16'd0);
    end else begin
      chk("R5 addr_match", {15'd0, addr_match}, {15'd0, m_am});
      chk("R6 frame_end", {15'd0, frame_end}, {15'd0, m_fe});
      chk("R7 ack_valid", {15'd0, ack_valid}, {15'd0, (m_st == 2)});
      chk("R11 busy", {15'd0, busy}, {15'd0, (m_st != 0)});
      if (m_st == 2) chk("R8 ack_data", {8'd0, ack_data}, {8'd0, m_b[m_idx]});
    end
    // stimulus for tick and ready
    tick_div = (tick_div + 1) % 4;
    sym_tick <= (tick_div == 0);
    ack_ready <= stall_mode ? ~ack_ready : 1'b1;
  end

  task automatic frame(input logic [15:0] fcf, input logic [7:0] seq, input logic [15:0] pan,
                       input logic [63:0] dst, input logic [7:0] cmd, input bit fcs,
                       input bit exp_ack, input string tag);
    @(negedge clk);
    frm_fcf = fcf; frm_seq = seq; frm_dst_pan = pan; frm_dst_addr = dst;
    frm_cmd_id = cmd; frm_fcs_ok = fcs; crc_in = {seq, ~seq};
    frm_done = 1;
    @(negedge clk);
    frm_done = 0;
    chk(tag, {15'd0, busy}, {15'd0, exp_ack});
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [15:0] PAN = 16'h1234;
  localparam logic [15:0] SHORT = 16'hBEEF;
  localparam logic [63:0] EXT = 64'h0011_2233_4455_6677;

  initial begin
    int t0;
    rst_n = 0; frm_done = 0; sym_tick = 0; ack_ready = 1;
    cfg_pan_id = PAN; cfg_short_addr = SHORT; cfg_ext_addr = EXT;
    cfg_pend = 1; cfg_ack_dis = 0; cfg_promisc = 0; cfg_fast_ack = 0;
    frm_fcf = 0; frm_seq = 0; frm_dst_pan = 0; frm_dst_addr = 0; frm_cmd_id = 0;
    frm_fcs_ok = 0; crc_in = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R8: matching data frame, short address
    frame(16'h0821, 8'h11, PAN, {48'd0, SHORT}, 8'h00, 1, 1, "R2 data short match acks");
    // R1: ack request clear, and a beacon with the bit set
    frame(16'h0801, 8'h12, PAN, {48'd0, SHORT}, 8'h00, 1, 0, "R1 no request no ack");
    frame(16'h0820, 8'h13, PAN, {48'd0, SHORT}, 8'h00, 1, 0, "R1 beacon type no ack");
    // R9 R10: data request command with stalling ready
    stall_mode = 1;
    frame(16'h0823, 8'h21, PAN, {48'd0, SHORT}, 8'h04, 1, 1, "R9 data request acks");
    frame(16'h0823, 8'h22, PAN, {48'd0, SHORT}, 8'h05, 1, 1, "R9 other command acks");
    stall_mode = 0;
    frame(16'h0821, 8'h23, PAN, {48'd0, SHORT}, 8'h04, 1, 1, "R9 data frame acks");
    // R3
    cfg_ack_dis = 1;
    frame(16'h0821, 8'h31, PAN, {48'd0, SHORT}, 8'h00, 1, 0, "R3 disabled no ack");
    cfg_ack_dis = 0;
    // R2 R6: bad FCS with match, then bad FCS without match, then promiscuous
    frame(16'h0821, 8'h41, PAN, {48'd0, SHORT}, 8'h00, 0, 0, "R2 bad fcs no ack");
    frame(16'h0821, 8'h42, 16'h5555, {48'd0, SHORT}, 8'h00, 0, 0, "R6 bad fcs mismatch");
    cfg_promisc = 1;
    frame(16'h0821, 8'h43, 16'h5555, {48'd0, SHORT}, 8'h00, 0, 0, "R6 promiscuous");
    cfg_promisc = 0;
    frame(16'h0821, 8'h44, PAN, {48'd0, 16'hBEEE}, 8'h00, 1, 0, "R2 short mismatch");
    // R4: broadcast short never acked, broadcast PAN accepted
    frame(16'h0821, 8'h51, PAN, {48'd0, 16'hFFFF}, 8'h00, 1, 0, "R4 broadcast short no ack");
    frame(16'h0821, 8'h52, 16'hFFFF, {48'd0, SHORT}, 8'h00, 1, 1, "R4 broadcast pan acks");
    // R2: extended addressing
    frame(16'h0C21, 8'h61, PAN, EXT, 8'h00, 1, 1, "R2 extended match acks");
    frame(16'h0C21, 8'h62, PAN, EXT ^ 64'h1, 8'h00, 1, 0, "R2 extended mismatch");
    frame(16'h0021, 8'h63, PAN, {48'd0, SHORT}, 8'h00, 1, 0, "R2 no dest mode");
    // R7: fast turnaround, count ticks until valid
    cfg_fast_ack = 1;
    frame(16'h0821, 8'h71, PAN, {48'd0, SHORT}, 8'h00, 1, 1, "R7 fast turnaround acks");
    cfg_fast_ack = 0;
    // R7 R11: strobe during turnaround ignored; measure span
    @(negedge clk);
    frm_fcf = 16'h0821; frm_seq = 8'h81; frm_dst_pan = PAN;
    frm_dst_addr = {48'd0, SHORT}; frm_fcs_ok = 1; crc_in = 16'hA55A;
    frm_done = 1;
    @(negedge clk);
    frm_done = 0;
    t0 = cyc;
    repeat (5) @(negedge clk);
    frm_fcf = 16'h0801; frm_seq = 8'h82; frm_done = 1;
    @(negedge clk);
    frm_done = 0;
    chk("R11 strobe while busy ignored", {14'd0, addr_match, frame_end}, 16'd0);
    while (!ack_valid) @(negedge clk);
    chk("R7 default turnaround span", 16'((cyc - t0) >= 4 * (TURN - 1) && (cyc - t0) <= 4 * TURN + 1),
        16'd1);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule